// File: doc/BRIEF.md
# Configurable Logic Macrocell

This block is one programmable logic cell. It takes a sum-of-products term and can pass it straight through, hold it in an edge-triggered register, or hold it in a level-sensitive latch. A static configuration chooses the storage mode, D or toggle register behaviour, the output polarity, and which of four shared clock/gate lines drives the storage element. Reset and preset terms, shared by every cell of a group, force the stored bit asynchronously. The cell drives an output toward its pin and an internal feedback value that is always available for routing back into the logic array.

A buried-cell option makes the storage element sample a pin input in place of the logic term, so that an unused cell can act as an input register or an input latch.

The shared clock/gate lines are treated as data sampled by the system clock `clk`. A register update happens on the first `clk` edge that sees the selected line high after it was low. The latch tracks its input while the gate is low, and the output follows that input combinationally during that time.

Top module: `logic_macrocell`

## Requirements
- R1: While `rst_n` is low the stored bit is 0. After reset the selected line's previous value is taken as 1, so a line that is already high does not count as a rising edge.
- R2: With `cfg_mode` = 2'b01 and `cfg_toggle` = 0, the stored bit takes the data input on the first `clk` edge at which the selected line is high after being low. At all other edges it holds.
- R3: `cfg_line_sel` (0 to 3) picks the bit of `gate_lines` used as clock or gate. Edges on the other lines have no effect.
- R4: With `cfg_mode` = 2'b01 and `cfg_toggle` = 1, a rising edge inverts the stored bit when the data input is 1 and leaves it unchanged when the data input is 0.
- R5: `cell_out` equals the feedback value XOR `cfg_invert`.
- R6: With `cfg_mode` = 2'b10, the feedback follows the data input while the selected line is low. While the line is high it holds the value held when the line rose.
- R7: With `cfg_mode` = 2'b00 or 2'b11, the feedback equals `sop_in` with no storage delay.
- R8: `async_clr` high forces the stored bit to 0 at once, without waiting for a clock, and keeps it at 0 through any clock edges.
- R9: `async_set` high with `async_clr` low forces the stored bit to 1 at once.
- R10: When `async_clr` and `async_set` are both high, the stored bit is 0.
- R11: With `cfg_pin_capture` = 1, the register and latch take `pin_in` in place of `sop_in`. The register then behaves as a D register even when `cfg_toggle` is 1.
- R12: `cell_fb` is taken before the polarity inversion, so `cfg_invert` never changes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the clock/gate lines |
| rst_n | input | 1 | Active-low asynchronous system reset |
| sop_in | input | 1 | Sum-of-products logic term |
| pin_in | input | 1 | Pin value for input-capture use |
| gate_lines | input | 4 | Shared clock/gate lines |
| async_clr | input | 1 | Shared asynchronous reset term |
| async_set | input | 1 | Shared asynchronous preset term |
| cfg_mode | input | 2 | 00/11 combinational, 01 register, 10 latch |
| cfg_toggle | input | 1 | 1 selects toggle register behaviour |
| cfg_invert | input | 1 | 1 inverts the output |
| cfg_line_sel | input | 2 | Index of the clock/gate line |
| cfg_pin_capture | input | 1 | 1 stores `pin_in` instead of `sop_in` |
| cell_out | output | 1 | Polarity-adjusted cell output |
| cell_fb | output | 1 | Internal feedback before inversion |

## Verification
The bench goes after the edge rule: a line held high across a data change must not capture again, and a design that stores on level would overwrite the register. It drives reset and preset together and in the middle of a clock period. A design with the wrong priority ends at 1, and a synchronous one shows the old value until the next edge. It also checks that toggle mode is dropped under pin capture and that inversion leaves the feedback alone, which catches a cell that toggles a pin sample or feeds back the inverted value. Latch checks cover both gate levels, so a latch with the gate polarity reversed fails at once.

// File: rtl/logic_macrocell.sv
module logic_macrocell (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sop_in,
  input  logic       pin_in,
  input  logic [3:0] gate_lines,
  input  logic       async_clr,
  input  logic       async_set,
  input  logic [1:0] cfg_mode,
  input  logic       cfg_toggle,
  input  logic       cfg_invert,
  input  logic [1:0] cfg_line_sel,
  input  logic       cfg_pin_capture,
  output logic       cell_out,
  output logic       cell_fb
);

  localparam logic [1:0] MODE_REG   = 2'b01;
  localparam logic [1:0] MODE_LATCH = 2'b10;

  logic line_now, line_prev, line_rise;
  logic data_src, stored, raw;
  logic is_reg, is_latch;

  assign line_now  = gate_lines[cfg_line_sel];
  assign line_rise = line_now & ~line_prev;
  assign data_src  = cfg_pin_capture ? pin_in : sop_in;
  assign is_reg    = (cfg_mode == MODE_REG);
  assign is_latch  = (cfg_mode == MODE_LATCH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) line_prev <= 1'b1;
    else        line_prev <= line_now;
  end

  always_ff @(posedge clk or negedge rst_n or posedge async_clr or posedge async_set) begin
    if (!rst_n)         stored <= 1'b0;
    else if (async_clr) stored <= 1'b0;
    else if (async_set) stored <= 1'b1;
    else if (is_reg && line_rise)
      stored <= (cfg_toggle && !cfg_pin_capture) ? (stored ^ data_src) : data_src;
    else if (is_latch && !line_now)
      stored <= data_src;
  end

  always_comb begin
    if (is_reg)
      raw = stored;
    else if (is_latch)
      raw = (!line_now && !async_clr && !async_set) ? data_src : stored;
    else
      raw = sop_in;
  end

  assign cell_fb  = raw;
  assign cell_out = raw ^ cfg_invert;

  // R8
  clr_forces_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    async_clr |-> !stored);

  // R9
  set_forces_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (async_set && !async_clr) |-> stored);

  // R2
  reg_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_reg && !line_rise && !async_clr && !async_set)
      |=> ($stable(stored) || async_clr || async_set));

  // R6
  latch_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_latch && line_now && !async_clr && !async_set)
      |=> ($stable(stored) || async_clr || async_set));

  // R7
  comb_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_reg && !is_latch) |-> (cell_fb == sop_in));

  // R5
  polarity_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_reg && !is_latch) |-> (cell_out == (sop_in ^ cfg_invert)));

endmodule

// File: tb/tb_logic_macrocell.sv
`timescale 1ns/1ps
module tb_logic_macrocell;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       sop_in, pin_in, async_clr, async_set;
  logic [3:0] gate_lines;
  logic [1:0] cfg_mode, cfg_line_sel;
  logic       cfg_toggle, cfg_invert, cfg_pin_capture;
  logic       cell_out, cell_fb;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  string     tag_q[$];
  logic [1:0] exp_q[$];

  logic_macrocell dut (
    .clk(clk), .rst_n(rst_n), .sop_in(sop_in), .pin_in(pin_in),
    .gate_lines(gate_lines), .async_clr(async_clr), .async_set(async_set),
    .cfg_mode(cfg_mode), .cfg_toggle(cfg_toggle), .cfg_invert(cfg_invert),
    .cfg_line_sel(cfg_line_sel), .cfg_pin_capture(cfg_pin_capture),
    .cell_out(cell_out), .cell_fb(cell_fb)
  );

  always #4 clk = ~clk;

  task automatic tick();
    @(negedge clk);
  endtask

  // driver side: queue expected {out, fb} once inputs have settled
  task automatic expect_now(input string tag, input logic eo, input logic ef);
    #1;
    tag_q.push_back(tag);
    exp_q.push_back({eo, ef});
    wait (exp_q.size() == 0);
  endtask

  task automatic pulse_line(input int idx);
    gate_lines[idx] = 1'b0; tick();
    gate_lines[idx] = 1'b1; tick();
  endtask

  // monitor side: pop and compare
  initial begin
    forever begin
      string t;
      logic [1:0] e;
      wait (exp_q.size() > 0);
      t = tag_q.pop_front();
      e = exp_q[0];
      checks++;
      if ({cell_out, cell_fb} !== e) begin
        errors++;
        $display("FAIL %s: out/fb actual=%b%b expected=%b%b", t, cell_out, cell_fb, e[1], e[0]);
      end
      void'(exp_q.pop_front());
    end
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 0; sop_in = 0; pin_in = 0; async_clr = 0; async_set = 0;
    gate_lines = 4'b0000; cfg_mode = 2'b01; cfg_toggle = 0; cfg_invert = 0;
    cfg_line_sel = 2'd0; cfg_pin_capture = 0;
    tick(); tick();
    expect_now("R1 reset clears", 1'b0, 1'b0);
    gate_lines[0] = 1'b1; sop_in = 1;
    tick();
    rst_n = 1;
    tick();
    expect_now("R1 high line after reset is no edge", 1'b0, 1'b0);
    gate_lines[0] = 1'b0;
    tick();

    // R2 D register
    sop_in = 1; tick();
    expect_now("R2 no edge holds", 1'b0, 1'b0);
    gate_lines[0] = 1'b1; tick();
    expect_now("R2 capture on rise", 1'b1, 1'b1);
    sop_in = 0; tick(); tick();
    expect_now("R2 level high does not capture", 1'b1, 1'b1);
    pulse_line(0);
    expect_now("R2 capture zero", 1'b0, 1'b0);

    // R3 line select
    gate_lines = 4'b0000; tick();
    cfg_line_sel = 2'd2; sop_in = 1; tick();
    pulse_line(0); pulse_line(1); pulse_line(3);
    expect_now("R3 other lines ignored", 1'b0, 1'b0);
    pulse_line(2);
    expect_now("R3 selected line captures", 1'b1, 1'b1);

    // R4 toggle
    cfg_toggle = 1; sop_in = 1;
    pulse_line(2);
    expect_now("R4 toggle to 0", 1'b0, 1'b0);
    pulse_line(2);
    expect_now("R4 toggle to 1", 1'b1, 1'b1);
    sop_in = 0;
    pulse_line(2);
    expect_now("R4 data 0 keeps", 1'b1, 1'b1);

    // R5 / R12 polarity
    cfg_invert = 1;
    expect_now("R5 output inverted", 1'b0, 1'b1);
    expect_now("R12 feedback not inverted", 1'b0, 1'b1);
    cfg_invert = 0; cfg_toggle = 0;

    // R6 latch on line 2
    gate_lines = 4'b0000; cfg_mode = 2'b10; sop_in = 0;
    expect_now("R6 transparent low", 1'b0, 1'b0);
    sop_in = 1;
    expect_now("R6 transparent follows", 1'b1, 1'b1);
    tick();
    gate_lines[2] = 1'b1; tick();
    sop_in = 0; tick(); tick();
    expect_now("R6 gate high holds", 1'b1, 1'b1);
    gate_lines[2] = 1'b0;
    expect_now("R6 gate low passes again", 1'b0, 1'b0);
    tick();

    // R7 combinational
    cfg_mode = 2'b00; sop_in = 1;
    expect_now("R7 comb follows 1", 1'b1, 1'b1);
    sop_in = 0;
    expect_now("R7 comb follows 0", 1'b0, 1'b0);
    cfg_mode = 2'b11; sop_in = 1; cfg_invert = 1;
    expect_now("R7 mode 11 comb inverted", 1'b0, 1'b1);
    cfg_invert = 0;

    // R8 async clear mid-cycle
    cfg_mode = 2'b01; sop_in = 1; gate_lines = 4'b0000; tick();
    pulse_line(2);
    expect_now("R8 setup stored 1", 1'b1, 1'b1);
    #2 async_clr = 1;
    expect_now("R8 clear before edge", 1'b0, 1'b0);
    pulse_line(2);
    expect_now("R8 clear held over edges", 1'b0, 1'b0);
    async_clr = 0; tick();

    // R9 async set
    sop_in = 0;
    #2 async_set = 1;
    expect_now("R9 preset before edge", 1'b1, 1'b1);
    // R10 both high
    async_clr = 1;
    expect_now("R10 clear wins", 1'b0, 1'b0);
    tick();
    async_clr = 0; async_set = 0; tick();

    // R11 pin capture, toggle ignored
    cfg_pin_capture = 1; cfg_toggle = 1; sop_in = 0; pin_in = 1;
    pulse_line(2);
    expect_now("R11 pin captured", 1'b1, 1'b1);
    pulse_line(2);
    expect_now("R11 no toggle on pin capture", 1'b1, 1'b1);
    pin_in = 0;
    pulse_line(2);
    expect_now("R11 pin captured 0", 1'b0, 1'b0);
    gate_lines = 4'b0000; cfg_mode = 2'b10; pin_in = 1; sop_in = 0;
    expect_now("R11 input latch passes pin", 1'b1, 1'b1);
    tick();

    wait (exp_q.size() == 0);
    #1;
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule